// File: doc/BRIEF.md
# Reservation Monitor with Atomic Memory Operations

This block sits between several processors and one shared memory port. It serves five kinds of access: a load that also reserves its address, a conditional store, a plain store, an atomic swap and an atomic fetch-and-increment. Each processor owns a single reservation, which is an address plus a valid flag. The block watches every write it sends to memory and drops any reservation whose address matches. A conditional store therefore writes memory only if nothing wrote that location since the same processor's reserving load. It reports success as 1 and failure as 0.

Requests are arbitrated one at a time, and a fixed priority gives the lowest processor index the first turn. A processor raises its request and holds the opcode, address and data steady until its response pulse arrives. It then drops the request. A small state machine runs each accepted operation through these states:

- `S_IDLE`: arbitrate and latch the winning request.
- `S_READ`: issue the memory read.
- `S_MERGE`: capture the read data, and set the reservation on a reserving load.
- `S_WRITE`: issue the memory write and break matching reservations.
- `S_REPLY`: pulse the response to the requester.

The transitions are:

- `S_IDLE` goes to `S_READ` for a reserving load, a swap or an increment.
- `S_IDLE` goes to `S_WRITE` for a plain store, or for a conditional store whose reservation is intact.
- `S_IDLE` goes to `S_REPLY` for a conditional store that fails, or for an unknown opcode.
- `S_READ` always goes to `S_MERGE`.
- `S_MERGE` goes to `S_REPLY` for a reserving load, and to `S_WRITE` otherwise.
- `S_WRITE` always goes to `S_REPLY`.
- `S_REPLY` always goes to `S_IDLE`.

The memory port returns read data one cycle after `mem_re`, and it writes on the clock edge while `mem_we` is high.

Top module: `resv_atomic_unit`

## Requirements
- R1: While reset is asserted and right after it, no response is pulsed and no memory read or write is issued. Reset clears every reservation, so a conditional store made just after reset fails.
- R2: A reserving load (opcode 0) returns the memory word at its address on `resp_data`, with `resp_ok`=1, three cycles after acceptance. It records a valid reservation for that processor on that address.
- R3: A conditional store (opcode 1) whose processor holds a valid reservation on the same address writes its data to memory and returns `resp_ok`=1, two cycles after acceptance.
- R4: A conditional store with no valid reservation, or with a reservation on a different address, leaves memory unchanged. It returns `resp_ok`=0 one cycle after acceptance.
- R5: Every conditional store clears its own processor's reservation, whether it succeeds or fails.
- R6: Every memory write clears all reservations on the written address, leaves reservations on other addresses intact, and returns `resp_ok`=1. The writes that count are a plain store (opcode 2, responding two cycles after acceptance), a successful conditional store, a swap and an increment.
- R7: A swap (opcode 3) returns the old memory word and writes the request data in its place, four cycles after acceptance. Used as a lock with data 1, a returned 0 means the lock was free and is now taken, and a returned 1 means it was already held.
- R8: A fetch-and-increment (opcode 4) returns the old word and writes the old word plus one, modulo 2^DW, four cycles after acceptance.
- R9: When several processors request at once, the lowest index is served first. The others stay pending and are served later with their held inputs. Read and write are never issued in the same cycle.
- R10: `resp_valid` carries at most one set bit, and it pulses for one cycle on the bit of the served processor. For stores, `resp_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPROC | Per-processor request, held until its response |
| req_op | input | NPROC*3 | Per-processor opcode: 0 load-reserve, 1 conditional store, 2 store, 3 swap, 4 increment |
| req_addr | input | NPROC*AW | Per-processor word address |
| req_wdata | input | NPROC*DW | Per-processor store or swap data |
| resp_valid | output | NPROC | One-cycle response pulse to the served processor |
| resp_data | output | DW | Old memory word for load, swap and increment; 0 for stores |
| resp_ok | output | 1 | 1 on success, 0 for a failed conditional store |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid the cycle after `mem_re` |

## Verification
The response is due a fixed number of cycles after the edge that accepts the request:

| Operation | Cycles to response |
|-----------|--------------------|
| Failed conditional store | 1 |
| Plain store, successful conditional store | 2 |
| Reserving load | 3 |
| Swap, increment | 4 |

The bench raises a request on a falling edge and counts falling edges until the response bit appears. It checks that count against the latency given by the opcode and by the expected success flag. Data and flag are sampled on that same falling edge, and the request is dropped there. One idle edge passes before the next request, so each count starts from an idle state machine.

// File: rtl/resv_atomic_pkg.sv
package resv_atomic_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD_RSV = 3'd0,
        OP_STORE_CND = 3'd1,
        OP_STORE = 3'd2,
        OP_SWAP = 3'd3,
        OP_INCR = 3'd4
    } atom_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_MERGE,
        S_WRITE,
        S_REPLY
    } atom_state_e;

endpackage

// File: rtl/resv_prio_arb.sv
module resv_prio_arb #(
    parameter int NPROC = 4,
    localparam int IW = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPROC-1:0] req,
    output logic [NPROC-1:0] gnt,
    output logic [IW-1:0]    gnt_idx,
    output logic             gnt_any
);

    always_comb begin
        gnt_idx = '0;
        for (int i = NPROC - 1; i >= 0; i--) begin
            if (req[i]) gnt_idx = IW'(i);
        end
        gnt_any = |req;
        gnt     = gnt_any ? (NPROC'(1) << gnt_idx) : '0;
    end

    // R9: at most one winner, and a raised request always produces one
    a_r9_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && ((req != '0) == (gnt != '0)));

    // R9: the winner carries the lowest raised index
    a_r9_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (req[0]) |-> gnt[0]);

endmodule

// File: rtl/resv_table.sv
module resv_table #(
    parameter int NPROC = 4,
    parameter int AW = 8,
    localparam int IW = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [IW-1:0] set_id,
    input  logic [AW-1:0] set_addr,
    input  logic          own_clr_en,
    input  logic [IW-1:0] own_clr_id,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [IW-1:0] chk_id,
    input  logic [AW-1:0] chk_addr,
    output logic          chk_hit
);

    logic [NPROC-1:0] vld_q;
    logic [AW-1:0]    tag_q [NPROC];

    for (genvar g = 0; g < NPROC; g++) begin : g_slot
        logic set_me, kill_me;
        assign set_me  = set_en && (set_id == IW'(g));
        assign kill_me = (own_clr_en && (own_clr_id == IW'(g))) ||
                         (wr_en && (tag_q[g] == wr_addr));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[g] <= 1'b0;
                tag_q[g] <= '0;
            end else if (set_me) begin
                vld_q[g] <= 1'b1;
                tag_q[g] <= set_addr;
            end else if (kill_me) begin
                vld_q[g] <= 1'b0;
            end
        end

        // R6: a write to a reserved address drops that reservation
        a_r6_write_breaks: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && vld_q[g] && tag_q[g] == wr_addr && !set_me) |=> !vld_q[g]);

        // R5: a conditional store drops its own reservation
        a_r5_own_drop: assert property (@(posedge clk) disable iff (!rst_n)
            (own_clr_en && own_clr_id == IW'(g) && !set_me) |=> !vld_q[g]);
    end

    assign chk_hit = vld_q[chk_id] && (tag_q[chk_id] == chk_addr);

endmodule

// File: rtl/resv_atomic_unit.sv
module resv_atomic_unit
    import resv_atomic_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPROC-1:0]    req_valid,
    input  logic [NPROC*3-1:0]  req_op,
    input  logic [NPROC*AW-1:0] req_addr,
    input  logic [NPROC*DW-1:0] req_wdata,
    output logic [NPROC-1:0]    resp_valid,
    output logic [DW-1:0]       resp_data,
    output logic                resp_ok,
    output logic                mem_re,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_wdata,
    input  logic [DW-1:0]       mem_rdata
);

    localparam int IW = (NPROC > 1) ? $clog2(NPROC) : 1;

    atom_state_e state_q, state_d;

    logic [NPROC-1:0] gnt;
    logic [IW-1:0]    gnt_idx;
    logic             gnt_any;
    logic             chk_hit;

    atom_op_e      in_op;
    logic [AW-1:0] in_addr;
    logic [DW-1:0] in_wdata;

    logic [IW-1:0] id_q;
    atom_op_e      op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] old_q;
    logic          ok_q;

    assign in_op    = atom_op_e'(req_op[gnt_idx*OP_W +: OP_W]);
    assign in_addr  = req_addr[gnt_idx*AW +: AW];
    assign in_wdata = req_wdata[gnt_idx*DW +: DW];

    resv_prio_arb #(.NPROC(NPROC)) i_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_valid),
        .gnt     (gnt),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    logic accept;
    assign accept = (state_q == S_IDLE) && gnt_any;

    resv_table #(.NPROC(NPROC), .AW(AW)) i_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     ((state_q == S_MERGE) && (op_q == OP_LOAD_RSV)),
        .set_id     (id_q),
        .set_addr   (addr_q),
        .own_clr_en (accept && (in_op == OP_STORE_CND)),
        .own_clr_id (gnt_idx),
        .wr_en      (mem_we),
        .wr_addr    (mem_addr),
        .chk_id     (gnt_idx),
        .chk_addr   (in_addr),
        .chk_hit    (chk_hit)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Captured operation context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q    <= '0;
            op_q    <= OP_LOAD_RSV;
            addr_q  <= '0;
            wdata_q <= '0;
            old_q   <= '0;
            ok_q    <= 1'b0;
        end else if (accept) begin
            id_q    <= gnt_idx;
            op_q    <= in_op;
            addr_q  <= in_addr;
            wdata_q <= in_wdata;
            old_q   <= '0;
            unique case (in_op)
                OP_STORE_CND: ok_q <= chk_hit;
                OP_LOAD_RSV, OP_STORE, OP_SWAP, OP_INCR: ok_q <= 1'b1;
                default: ok_q <= 1'b0;
            endcase
        end else if (state_q == S_MERGE) begin
            old_q <= mem_rdata;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (gnt_any) begin
                    unique case (in_op)
                        OP_LOAD_RSV, OP_SWAP, OP_INCR: state_d = S_READ;
                        OP_STORE:                      state_d = S_WRITE;
                        OP_STORE_CND: state_d = chk_hit ? S_WRITE : S_REPLY;
                        default:                       state_d = S_REPLY;
                    endcase
                end
            end
            S_READ:  state_d = S_MERGE;
            S_MERGE: state_d = (op_q == OP_LOAD_RSV) ? S_REPLY : S_WRITE;
            S_WRITE: state_d = S_REPLY;
            S_REPLY: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_re     = (state_q == S_READ);
        mem_we     = (state_q == S_WRITE);
        mem_addr   = addr_q;
        mem_wdata  = (op_q == OP_INCR) ? (old_q + DW'(1)) : wdata_q;
        resp_valid = (state_q == S_REPLY) ? (NPROC'(1) << id_q) : '0;
        resp_data  = old_q;
        resp_ok    = ok_q;
    end

    // R9: a single memory access per cycle
    a_r9_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R10: responses go to one processor at a time
    a_r10_resp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(resp_valid));

    // R3: a successful conditional store was written in the previous cycle
    a_r3_success_wrote: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid != '0 && op_q == OP_STORE_CND && resp_ok) |-> $past(mem_we));

    // R4: a failed response never follows a write
    a_r4_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid != '0 && !resp_ok) |-> !$past(mem_we));

    // R8: the increment writes the word read one cycle earlier plus one
    a_r8_incr_value: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && op_q == OP_INCR) |-> mem_wdata == $past(mem_rdata) + DW'(1));

    // R2: a reserving load returns the word delivered by memory
    a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MERGE && op_q == OP_LOAD_RSV) |=> resp_data == $past(mem_rdata));

endmodule

// File: tb/test_resv_atomic_unit.sv
module test_resv_atomic_unit;

    localparam int NP = 4;
    localparam int AW = 8;
    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     req_valid = '0;
    logic [NP*3-1:0]   req_op = '0;
    logic [NP*AW-1:0]  req_addr = '0;
    logic [NP*DW-1:0]  req_wdata = '0;
    logic [NP-1:0]     resp_valid;
    logic [DW-1:0]     resp_data;
    logic              resp_ok;
    logic              mem_re, mem_we;
    logic [AW-1:0]     mem_addr;
    logic [DW-1:0]     mem_wdata;
    logic [DW-1:0]     mem_rdata = '0;

    logic [DW-1:0] mem [1 << AW];

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    resv_atomic_unit #(.NPROC(NP), .AW(AW), .DW(DW)) i_resv_atomic_unit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_data(resp_data), .resp_ok(resp_ok),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    end

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
    end

    typedef struct packed {
        logic [1:0]    p;
        logic [2:0]    op;
        logic [AW-1:0] a;
        logic [DW-1:0] w;
        logic [DW-1:0] d;
        logic          ok;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 3'd0, 8'd10, 32'd0, 32'd0, 1'b1},
        '{2'd0, 3'd1, 8'd10, 32'd5, 32'd0, 1'b1},
        '{2'd0, 3'd1, 8'd10, 32'd7, 32'd0, 1'b0},
        '{2'd0, 3'd0, 8'd10, 32'd0, 32'd5, 1'b1},
        '{2'd1, 3'd2, 8'd10, 32'd9, 32'd0, 1'b1},
        '{2'd0, 3'd1, 8'd10, 32'd6, 32'd0, 1'b0},
        '{2'd0, 3'd0, 8'd10, 32'd0, 32'd9, 1'b1},
        '{2'd2, 3'd0, 8'd10, 32'd0, 32'd9, 1'b1},
        '{2'd2, 3'd1, 8'd10, 32'd3, 32'd0, 1'b1},
        '{2'd0, 3'd1, 8'd10, 32'd4, 32'd0, 1'b0},
        '{2'd1, 3'd0, 8'd20, 32'd0, 32'd0, 1'b1},
        '{2'd1, 3'd1, 8'd21, 32'd1, 32'd0, 1'b0},
        '{2'd1, 3'd1, 8'd20, 32'd1, 32'd0, 1'b0},
        '{2'd3, 3'd3, 8'd30, 32'd1, 32'd0, 1'b1},
        '{2'd2, 3'd3, 8'd30, 32'd1, 32'd1, 1'b1},
        '{2'd0, 3'd0, 8'd40, 32'd0, 32'd0, 1'b1},
        '{2'd1, 3'd4, 8'd40, 32'd0, 32'd0, 1'b1},
        '{2'd0, 3'd1, 8'd40, 32'd8, 32'd0, 1'b0},
        '{2'd3, 3'd4, 8'd40, 32'd0, 32'd1, 1'b1},
        '{2'd0, 3'd0, 8'd40, 32'd0, 32'd2, 1'b1},
        '{2'd2, 3'd2, 8'd41, 32'd5, 32'd0, 1'b1},
        '{2'd0, 3'd1, 8'd40, 32'd8, 32'd0, 1'b1},
        '{2'd3, 3'd0, 8'd40, 32'd0, 32'd8, 1'b1},
        '{2'd2, 3'd3, 8'd40, 32'd0, 32'd8, 1'b1},
        '{2'd3, 3'd1, 8'd40, 32'd1, 32'd0, 1'b0},
        '{2'd1, 3'd0, 8'd10, 32'd0, 32'd3, 1'b1},
        '{2'd0, 3'd2, 8'd50, 32'hFFFF_FFFF, 32'd0, 1'b1},
        '{2'd1, 3'd4, 8'd50, 32'd0, 32'hFFFF_FFFF, 1'b1},
        '{2'd1, 3'd0, 8'd50, 32'd0, 32'd0, 1'b1}
    };

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] op, input logic ok);
        case (op)
            3'd0: return "R2 load-reserve";
            3'd1: return ok ? "R3 cond-store ok" : "R4 cond-store fail";
            3'd2: return "R6 store";
            3'd3: return "R7 swap";
            default: return "R8 increment";
        endcase
    endfunction

    function automatic int lat_of(input logic [2:0] op, input logic ok);
        case (op)
            3'd0: return 3;
            3'd1: return ok ? 2 : 1;
            3'd2: return 2;
            default: return 4;
        endcase
    endfunction

    task automatic drive(input int p, input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] w);
        req_op[p*3 +: 3]     = op;
        req_addr[p*AW +: AW] = a;
        req_wdata[p*DW +: DW] = w;
        req_valid[p]         = 1'b1;
    endtask

    task automatic await(input int p, output int cnt);
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!resp_valid[p] && cnt < 50);
    endtask

    task automatic run_op(input int p, input logic [2:0] op, input logic [AW-1:0] a,
                          input logic [DW-1:0] w, input logic [DW-1:0] d, input logic ok);
        int cnt;
        string tag;
        tag = tag_of(op, ok);
        drive(p, op, a, w);
        await(p, cnt);
        check({tag, " latency"}, DW'(cnt), DW'(lat_of(op, ok)));
        check({tag, " r10_resp_target"}, DW'(resp_valid), DW'(1 << p));
        check({tag, " data"}, resp_data, d);
        check({tag, " flag"}, DW'(resp_ok), DW'(ok));
        req_valid[p] = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        // R1: quiet outputs under reset
        check("R1 resp under reset", DW'(resp_valid), '0);
        check("R1 mem strobes under reset", DW'({mem_re, mem_we}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 resp after reset", DW'(resp_valid), '0);
        check("R1 mem strobes after reset", DW'({mem_re, mem_we}), '0);

        for (int v = 0; v < NV; v++)
            run_op(VEC[v].p, VEC[v].op, VEC[v].a, VEC[v].w, VEC[v].d, VEC[v].ok);

        // R6 / R4: failed conditional stores left memory untouched (read via load)
        run_op(3, 3'd0, 8'd20, '0, 32'd0, 1'b1);

        // R9: p1 and p3 swap on the same word together; p1 wins
        drive(1, 3'd3, 8'd60, 32'd5);
        drive(3, 3'd3, 8'd60, 32'd7);
        await(1, cnt);
        check("R9 winner latency", DW'(cnt), 32'd4);
        check("R9 winner is p1", DW'(resp_valid), 32'b0010);
        check("R9 winner old value", resp_data, 32'd0);
        req_valid[1] = 1'b0;
        await(3, cnt);
        check("R9 pending p3 served", DW'(resp_valid), 32'b1000);
        check("R9 p3 sees p1 data", resp_data, 32'd5);
        req_valid[3] = 1'b0;
        @(negedge clk);
        run_op(0, 3'd0, 8'd60, '0, 32'd7, 1'b1);

        // R1: reset drops a live reservation
        run_op(0, 3'd0, 8'd70, '0, 32'd0, 1'b1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        drive(0, 3'd1, 8'd70, 32'd4);
        await(0, cnt);
        check("R1 reservation cleared by reset", DW'(resp_ok), '0);
        req_valid[0] = 1'b0;
        @(negedge clk);
        run_op(2, 3'd0, 8'd70, '0, 32'd0, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule